// File: doc/BRIEF.md
# Fixed-Period PWM Generator with Host Latches

This block turns an 8-bit pulse-width word into a pair of complementary switching outputs at a fixed period of 128 ticks. A host writes two byte-wide latches through a chip-select write port. A select line chooses between the width holding latch and the control latch. The width takes effect only when a new period begins, so a write that arrives mid-period never shortens or stretches the pulse in progress.

The control latch sets the tick rate: a tick on every clock, on every second clock, or on every fourth clock. It also holds a run enable, a half-resolution mode, a dead-time count, and a lock that freezes the control latch until reset. A trip input is meant for cycle-by-cycle current limiting. It turns both outputs off at once and keeps them off until the next period begins.

Top module: `dpwm_unit`

## Requirements
- R1: After a synchronous reset, both outputs are low, the control latch is 0 (stopped, unlocked), and the width latch is 0.
- R2: On a clock edge with `wr_cs_n` low, `wr_sel`=0 loads `wr_data` into the width holding latch, and `wr_sel`=1 loads it into the control latch. Control bit 7 is run, bit 6 is lock, bits 5:4 are the prescale select, bit 3 is coarse, and bits 2:0 are the dead time.
- R3: A period is 128 ticks. While running, the high side is driven for the first W ticks of each period, where W is the active width. W=0 gives a constant low side, and W≥128 gives a constant high side.
- R4: A width write reaches the active compare value only at a period boundary. The period in progress keeps its old width.
- R5: Prescale select 0 gives a tick on every clock. Select 1 gives a tick on every 2nd clock. Selects 2 and 3 give a tick on every 4th clock. The period is therefore 128, 256 or 512 clocks.
- R6: With coarse set, bit 0 of the width word is cleared when it is loaded into the active compare value.
- R7: With run clear, both outputs are low from the clock after the control latch is cleared.
- R8: A high `trip_in` drives both outputs low from the next clock. They stay low for the rest of that period, even after `trip_in` falls, and switching resumes at the next period start.
- R9: While lock is set, control-latch writes are ignored until reset. Width writes still take effect.
- R10: When the drive side changes, both outputs stay low for D extra clocks before the new side turns on, where D is the dead-time field. Turning off is not delayed.
- R11: The two outputs are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_cs_n | input | 1 | Active-low write strobe |
| wr_sel | input | 1 | 0 selects the width latch, 1 selects the control latch |
| wr_data | input | 8 | Write data |
| trip_in | input | 1 | Output-disable request |
| pwm_hi | output | 1 | High-side drive |
| pwm_lo | output | 1 | Low-side drive |

## Verification
A wrong period counter or prescaler shows up as a shifted edge on `pwm_hi` within one period, which is at most 512 clocks. A stale or early-loaded compare value shows up as a wrong high-time in the very period where the write lands. A trip latch that clears too soon shows the low side turning back on before the period ends. A wrong dead-time counter shows up one edge later, at the next side change, as a gap of the wrong length.

// File: rtl/dpwm_pkg.sv
`timescale 1ns/1ps
package dpwm_pkg;
    localparam int CNT_W   = 7;                 // period = 2**CNT_W ticks
    localparam int WIDTH_W = 8;
    localparam int DEAD_W  = 3;
    localparam int PRE_W   = 2;
    localparam logic [CNT_W-1:0] CNT_LAST = {CNT_W{1'b1}};

    typedef struct packed {
        logic              run;
        logic              lock;
        logic [1:0]        ps;
        logic              coarse;
        logic [DEAD_W-1:0] dead;
    } ctrl_t;

    typedef enum logic [1:0] {
        PH_OFF = 2'd0,
        PH_HI  = 2'd1,
        PH_LO  = 2'd2
    } phase_t;

    function automatic logic [PRE_W-1:0] prescale_limit(input logic [1:0] ps);
        case (ps)
            2'd0:    return 2'd0;
            2'd1:    return 2'd1;
            default: return 2'd3;
        endcase
    endfunction

    function automatic logic [WIDTH_W-1:0] load_width(input logic [WIDTH_W-1:0] w,
                                                      input logic coarse);
        return coarse ? {w[WIDTH_W-1:1], 1'b0} : w;
    endfunction
endpackage

// File: rtl/dpwm_regs.sv
`timescale 1ns/1ps
module dpwm_regs
    import dpwm_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_cs_n,
    input  logic               wr_sel,
    input  logic [WIDTH_W-1:0] wr_data,
    output logic [WIDTH_W-1:0] hold_q,
    output ctrl_t              ctrl_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q <= '0;
            ctrl_q <= '0;
        end else if (!wr_cs_n) begin
            if (wr_sel) begin
                if (!ctrl_q.lock) ctrl_q <= ctrl_t'(wr_data);
            end else begin
                hold_q <= wr_data;
            end
        end
    end
endmodule

// File: rtl/dpwm_timebase.sv
`timescale 1ns/1ps
module dpwm_timebase
    import dpwm_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  ctrl_t              ctrl,
    input  logic [WIDTH_W-1:0] hold,
    input  logic               trip_in,
    output logic               boundary,
    output logic [WIDTH_W-1:0] active_q,
    output phase_t             tgt
);
    logic [PRE_W-1:0] pre_q;
    logic [CNT_W-1:0] cnt_q;
    logic             trl_q;
    logic             tick;
    logic             en;

    assign tick     = pre_q >= prescale_limit(ctrl.ps);
    assign boundary = tick && (cnt_q == CNT_LAST);
    assign en       = ctrl.run && !trip_in && !trl_q;

    always_comb begin
        if (!en)                                             tgt = PH_OFF;
        else if ({{(WIDTH_W-CNT_W){1'b0}}, cnt_q} < active_q) tgt = PH_HI;
        else                                                 tgt = PH_LO;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pre_q    <= '0;
            cnt_q    <= '0;
            active_q <= '0;
            trl_q    <= 1'b0;
        end else begin
            trl_q <= trip_in || (trl_q && !boundary);
            if (tick) begin
                pre_q <= '0;
                cnt_q <= cnt_q + 1'b1;
                if (boundary) active_q <= load_width(hold, ctrl.coarse);
            end else begin
                pre_q <= pre_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/dpwm_deadband.sv
`timescale 1ns/1ps
module dpwm_deadband
    import dpwm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  phase_t            tgt,
    input  logic [DEAD_W-1:0] dead,
    output logic              pwm_hi,
    output logic              pwm_lo
);
    phase_t            ph_q;
    logic [DEAD_W-1:0] dc_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q <= PH_OFF;
            dc_q <= '0;
        end else if (tgt != ph_q) begin
            ph_q <= tgt;
            dc_q <= dead;
        end else if (dc_q != '0) begin
            dc_q <= dc_q - 1'b1;
        end
    end

    assign pwm_hi = (ph_q == PH_HI) && (dc_q == '0);
    assign pwm_lo = (ph_q == PH_LO) && (dc_q == '0);
endmodule

// File: rtl/dpwm_unit.sv
`timescale 1ns/1ps
module dpwm_unit
    import dpwm_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_cs_n,
    input  logic       wr_sel,
    input  logic [7:0] wr_data,
    input  logic       trip_in,
    output logic       pwm_hi,
    output logic       pwm_lo
);
    logic [WIDTH_W-1:0] hold_q;
    ctrl_t              ctrl_q;
    logic               boundary;
    logic [WIDTH_W-1:0] active_q;
    phase_t             tgt;

    dpwm_regs u_regs (
        .clk(clk), .rst(rst), .wr_cs_n(wr_cs_n), .wr_sel(wr_sel),
        .wr_data(wr_data), .hold_q(hold_q), .ctrl_q(ctrl_q)
    );

    dpwm_timebase u_tb (
        .clk(clk), .rst(rst), .ctrl(ctrl_q), .hold(hold_q), .trip_in(trip_in),
        .boundary(boundary), .active_q(active_q), .tgt(tgt)
    );

    dpwm_deadband u_db (
        .clk(clk), .rst(rst), .tgt(tgt), .dead(ctrl_q.dead),
        .pwm_hi(pwm_hi), .pwm_lo(pwm_lo)
    );
endmodule

// File: rtl/dpwm_unit_chk.sv
`timescale 1ns/1ps
module dpwm_unit_chk
    import dpwm_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               wr_cs_n,
    input logic               wr_sel,
    input logic               trip_in,
    input logic               pwm_hi,
    input logic               pwm_lo,
    input ctrl_t              ctrl_q,
    input logic               boundary,
    input logic [WIDTH_W-1:0] active_q
);
    p_exclusive_r11: assert property (@(posedge clk) disable iff (rst)
        !(pwm_hi && pwm_lo));

    p_trip_off_r8: assert property (@(posedge clk) disable iff (rst)
        trip_in |=> (!pwm_hi && !pwm_lo));

    p_stop_off_r7: assert property (@(posedge clk) disable iff (rst)
        !ctrl_q.run |=> (!pwm_hi && !pwm_lo));

    p_lock_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q.lock && !wr_cs_n && wr_sel) |=> $stable(ctrl_q));

    p_width_at_edge_r4: assert property (@(posedge clk) disable iff (rst)
        !boundary |=> $stable(active_q));
endmodule

bind dpwm_unit dpwm_unit_chk u_chk (
    .clk(clk), .rst(rst), .wr_cs_n(wr_cs_n), .wr_sel(wr_sel), .trip_in(trip_in),
    .pwm_hi(pwm_hi), .pwm_lo(pwm_lo), .ctrl_q(ctrl_q), .boundary(boundary),
    .active_q(active_q)
);

// File: tb/dpwm_unit_bench.sv
`timescale 1ns/1ps
module dpwm_unit_bench;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic wr_cs_n = 1'b1;
    logic wr_sel = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic trip_in = 1'b0;
    logic pwm_hi, pwm_lo;

    int checks = 0;
    int errors = 0;
    string cur_req = "R1";
    bit finished = 0;

    always #2.5 clk = ~clk;

    dpwm_unit u_dpwm_unit (
        .clk(clk), .rst(rst), .wr_cs_n(wr_cs_n), .wr_sel(wr_sel),
        .wr_data(wr_data), .trip_in(trip_in), .pwm_hi(pwm_hi), .pwm_lo(pwm_lo)
    );

    // behavioural reference model, advanced once per clock
    int m_ctrl, m_hold, m_act, m_pre, m_cnt, m_trl, m_ph, m_dc;
    int m_lim, m_tgt;
    bit m_tick, m_bnd, m_en;

    always @(posedge clk) begin
        if (rst) begin
            m_ctrl = 0; m_hold = 0; m_act = 0; m_pre = 0;
            m_cnt = 0; m_trl = 0; m_ph = 0; m_dc = 0;
        end else begin
            case ((m_ctrl / 16) % 4)
                0: m_lim = 0;
                1: m_lim = 1;
                default: m_lim = 3;
            endcase
            m_tick = (m_pre >= m_lim);
            m_bnd  = m_tick && (m_cnt == 127);
            m_en   = ((m_ctrl & 128) != 0) && !trip_in && (m_trl == 0);
            m_tgt  = !m_en ? 0 : ((m_cnt < m_act) ? 1 : 2);
            if (m_tgt != m_ph) begin
                m_ph = m_tgt; m_dc = m_ctrl % 8;
            end else if (m_dc > 0) m_dc = m_dc - 1;
            m_trl = (trip_in || (m_trl != 0 && !m_bnd)) ? 1 : 0;
            if (m_tick) begin
                m_pre = 0;
                if (m_bnd) begin
                    m_cnt = 0;
                    m_act = ((m_ctrl & 8) != 0) ? (m_hold & 254) : m_hold;
                end else m_cnt = m_cnt + 1;
            end else m_pre = m_pre + 1;
            if (!wr_cs_n) begin
                if (!wr_sel) m_hold = wr_data;
                else if ((m_ctrl & 64) == 0) m_ctrl = wr_data;
            end
        end
        #1;
        if (!rst) begin
            checks++;
            if (pwm_hi !== (m_ph == 1 && m_dc == 0) || pwm_lo !== (m_ph == 2 && m_dc == 0)) begin
                errors++;
                $display("FAIL %s: model mismatch hi/lo actual=%b%b expected=%b%b", cur_req,
                         pwm_hi, pwm_lo, (m_ph == 1 && m_dc == 0), (m_ph == 2 && m_dc == 0));
            end
            checks++;
            if (pwm_hi && pwm_lo) begin // R11
                errors++;
                $display("FAIL R11: both high actual=11 expected=not 11");
            end
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic sel, input logic [7:0] d);
        @(negedge clk);
        wr_cs_n = 1'b0; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_cs_n = 1'b1;
    endtask

    // waits for a rising pwm_hi, then measures until the next one
    task automatic measure(output int per, output int hic, output int offc);
        logic prev;
        bit rise;
        int g;
        prev = pwm_hi; g = 0; rise = 0;
        while (!rise && g < 3000) begin
            @(negedge clk); g++;
            rise = !prev && pwm_hi; prev = pwm_hi;
        end
        per = 0; hic = 0; offc = 0; rise = 0;
        while (!rise && per < 3000) begin
            hic += pwm_hi;
            offc += (!pwm_hi && !pwm_lo);
            per++;
            @(negedge clk);
            rise = !prev && pwm_hi; prev = pwm_hi;
        end
    endtask

    task automatic count_hi(input int n, output int hic, output int loc);
        hic = 0; loc = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            hic += pwm_hi; loc += pwm_lo;
        end
    endtask

    initial begin
        #(5ns * 150000);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int per, hic, offc, loc;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        cur_req = "R1";
        check("R1 hi after reset", pwm_hi, 0);
        check("R1 lo after reset", pwm_lo, 0);

        cur_req = "R2";
        wr(1'b0, 8'd40);
        wr(1'b1, 8'h80);
        cur_req = "R3";
        measure(per, hic, offc);
        measure(per, hic, offc);
        check("R3 period", per, 128);
        check("R3 high time 40", hic, 40);
        check("R2 no dead gap", offc, 0);

        cur_req = "R4";
        measure(per, hic, offc);
        wr_cs_n = 1'b0; wr_sel = 1'b0; wr_data = 8'd10;
        @(negedge clk); wr_cs_n = 1'b1;
        hic = pwm_hi; loc = 0;
        count_hi(99, per, loc);
        check("R4 old width kept", hic + per, 39);
        measure(per, hic, offc);
        check("R4 new width next period", hic, 10);

        cur_req = "R3";
        wr(1'b0, 8'd0);
        repeat (300) @(negedge clk);
        count_hi(200, hic, loc);
        check("R3 width 0 no high", hic, 0);
        check("R3 width 0 low held", loc, 200);
        wr(1'b0, 8'd200);
        repeat (300) @(negedge clk);
        count_hi(200, hic, loc);
        check("R3 width 200 all high", hic, 200);

        cur_req = "R5";
        wr(1'b0, 8'd40);
        wr(1'b1, 8'h90);
        measure(per, hic, offc);
        measure(per, hic, offc);
        check("R5 div2 period", per, 256);
        check("R5 div2 high", hic, 80);
        wr(1'b1, 8'hA0);
        measure(per, hic, offc);
        measure(per, hic, offc);
        check("R5 div4 period", per, 512);
        check("R5 div4 high", hic, 160);

        cur_req = "R6";
        wr(1'b0, 8'd41);
        wr(1'b1, 8'h88);
        measure(per, hic, offc);
        measure(per, hic, offc);
        check("R6 coarse high", hic, 40);

        cur_req = "R10";
        wr(1'b0, 8'd64);
        wr(1'b1, 8'h85);
        measure(per, hic, offc);
        measure(per, hic, offc);
        check("R10 period", per, 128);
        check("R10 high minus dead", hic, 59);
        check("R10 both-off clocks", offc, 10);

        cur_req = "R8";
        wr(1'b0, 8'd100);
        wr(1'b1, 8'h80);
        measure(per, hic, offc);
        repeat (20) @(negedge clk);
        trip_in = 1'b1;
        @(negedge clk);
        trip_in = 1'b0;
        check("R8 hi off next clock", pwm_hi, 0);
        check("R8 lo off next clock", pwm_lo, 0);
        count_hi(100, hic, loc);
        check("R8 stays off hi", hic, 0);
        check("R8 stays off lo", loc, 0);
        measure(per, hic, offc);
        check("R8 resumes next period", hic, 100);

        cur_req = "R9";
        wr(1'b1, 8'hC0);
        wr(1'b1, 8'h00);
        wr(1'b0, 8'd70);
        measure(per, hic, offc);
        measure(per, hic, offc);
        check("R9 locked still runs", per, 128);
        check("R9 width write still works", hic, 70);

        cur_req = "R1";
        @(negedge clk); rst = 1'b1;
        repeat (2) @(negedge clk); rst = 1'b0;
        count_hi(300, hic, loc);
        check("R1 reset stops hi", hic, 0);
        check("R1 reset stops lo", loc, 0);

        cur_req = "R7";
        wr(1'b0, 8'd50);
        wr(1'b1, 8'h80);
        measure(per, hic, offc);
        measure(per, hic, offc);
        check("R9 lock cleared by reset", hic, 50);
        wr(1'b1, 8'h00);
        @(negedge clk);
        count_hi(300, hic, loc);
        check("R7 stop hi", hic, 0);
        check("R7 stop lo", loc, 0);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule